// File: doc/BRIEF.md
# Fast Reduction Unit for Three Special Primes

This unit takes a double-width product that is still in redundant carry-save form and reduces it modulo one of three fixed primes of special shape: p192 = 2^192 − 2^64 − 1, p224 = 2^224 − 2^96 + 1 and p256 = 2^256 − 2^224 + 2^192 + 2^96 − 1. It sits behind a wide multiplier. The multiplier hands over sixteen 32-bit partial-sum words and sixteen saved multibit carries. This unit turns them into one fully reduced residue.

The unit has three stages. The first stage adds the carries into the sum words to form the plain 512-bit product. The second stage regroups the product's 32-bit words into a positive term U and a negative term V, using a shape that depends on the selected prime. It then adds a fixed multiple of p, so the difference can never go below zero. The third stage subtracts the largest multiple of p that still fits, which places the result in [0, p).

Both edges of the unit use a valid/ready handshake. The whole pipeline moves as one unit. It advances on every clock edge unless the output holds a result that the consumer has not yet taken. The input is ready exactly when the pipeline can advance, so a stalled consumer stops new products from entering. When `out_ready` stays high, the unit takes one product per cycle and each result appears three cycles after it was accepted.

Top module: `nfr_fast_reduce`

## Requirements
- R1: The field code on `in_field` selects the modulus: 2'b00 picks p192, 2'b01 picks p224 and 2'b10 picks p256. For an accepted product Z, `out_data` equals Z mod p. Z must be below 2^384 for p192, below 2^448 for p224 and below 2^512 for p256.
- R2: The product is taken as Z = Σ s_j·2^(32j) + Σ c_j·2^(32j), modulo 2^512. Here s_j is `in_sum[32j+31:32j]` for j = 0..15, and c_j is the 8-bit field `in_carry[8(j−1)+7:8(j−1)]` for j = 1..16. The result does not depend on how Z is split between sums and carries.
- R3: Every valid output is below the selected p. Bits of `out_data` above the field width (192, 224 or 256) are zero.
- R4: A product presented with the reserved code 2'b11 is accepted, but it never produces an output beat. A product offered while `in_ready` is low is not accepted.
- R5: While `out_ready` is held high, a product accepted at one clock edge appears on `out_valid` after the third edge that follows it. Back-to-back products are accepted on every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_field` stay stable, `out_valid` stays high and `in_ready` is low. `out_field` carries the code of the product that produced the beat.
- R7: While `rst_n` is low, and directly after it is released, `out_valid` is low and `in_ready` is high.
- R8: Products whose word regrouping gives U − V < 0 still reduce to the correct residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A product is offered |
| in_ready | output | 1 | Unit accepts the offered product this cycle |
| in_field | input | 2 | Modulus select code |
| in_sum | input | 512 | Sixteen 32-bit partial-sum words, word 0 lowest |
| in_carry | input | 128 | Sixteen 8-bit saved carries; carry j is weighted 2^(32j) |
| out_valid | output | 1 | A reduced result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_field | output | 2 | Modulus code of the presented result |
| out_data | output | 256 | Reduced residue, zero above the field width |

## Verification
The bench aims at the extremes of the residue range. It drives Z = 0, p − 1, p, (p − 1)^2 and the largest legal product for each field. A correction stage with too few steps, or with an off-by-one bound, would leave a value at or above p, or would wrap one below zero. It also drives products that hold only high words, so that V exceeds U. A design without a large enough offset would return a huge wrapped number. Random carry-save splits check that the merge weights each carry at its word. A carry placed one word too low gives a wrong residue for almost every input. Random stalls on the output check that a held beat does not change and that no product is lost or duplicated. Reserved-code products check that no stray beat appears, which would put the output stream out of step with the reference queue.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 16;
  localparam int CARRY_W = 8;
  localparam int PROD_W  = WORD_W * N_WORDS;
  localparam int RES_W   = 256;
  localparam int EXT_W   = RES_W + 6;
  localparam int OFFSET_K = 5;   // multiples of p added so U - V + k*p > 0
  localparam int KMAX    = 13;   // (U - V + 5p) < 14p for every field

  typedef enum logic [1:0] {
    FLD_192  = 2'b00,
    FLD_224  = 2'b01,
    FLD_256  = 2'b10,
    FLD_RSVD = 2'b11
  } field_e;

  function automatic logic [RES_W-1:0] prime_of(input field_e f);
    logic [RES_W-1:0] one;
    one = RES_W'(1);
    case (f)
      FLD_192: prime_of = (one << 192) - (one << 64) - one;
      FLD_224: prime_of = (one << 224) - (one << 96) + one;
      FLD_256: prime_of = (one << 192) + (one << 96) - one - (one << 224);
      default: prime_of = '0;
    endcase
  endfunction

  // eight 32-bit words, highest first, into one field-wide value
  function automatic logic [EXT_W-1:0] w8(
    input logic [WORD_W-1:0] h7, h6, h5, h4, h3, h2, h1, h0);
    w8 = EXT_W'({h7, h6, h5, h4, h3, h2, h1, h0});
  endfunction
endpackage

// File: rtl/nfr_merge.sv
module nfr_merge
  import nfr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       vld_i,
  input  field_e                     fld_i,
  input  logic [PROD_W-1:0]          sum_i,
  input  logic [N_WORDS*CARRY_W-1:0] carry_i,
  output logic                       vld_o,
  output field_e                     fld_o,
  output logic [PROD_W-1:0]          prod_o
);
  logic [PROD_W-1:0] acc;

  always_comb begin
    acc = sum_i;
    for (int j = 1; j <= N_WORDS; j++) begin
      acc = acc + (PROD_W'(carry_i[(j-1)*CARRY_W +: CARRY_W]) << (WORD_W * j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      fld_o <= FLD_192;
    end else if (en) begin
      vld_o <= vld_i && (fld_i != FLD_RSVD);
      fld_o <= fld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) prod_o <= acc;
  end
endmodule

// File: rtl/nfr_fold.sv
module nfr_fold
  import nfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vld_i,
  input  field_e            fld_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              vld_o,
  output field_e            fld_o,
  output logic [EXT_W-1:0]  ext_o
);
  logic [WORD_W-1:0] a [N_WORDS];
  logic [EXT_W-1:0]  pos, neg, offs;
  localparam logic [WORD_W-1:0] Z = '0;

  always_comb begin
    for (int k = 0; k < N_WORDS; k++) a[k] = prod_i[WORD_W*k +: WORD_W];
    pos = '0;
    neg = '0;
    case (fld_i)
      FLD_192: begin
        pos = w8(Z, Z, a[5], a[4], a[3], a[2], a[1], a[0])
            + w8(Z, Z, Z, Z, a[7], a[6], a[7], a[6])
            + w8(Z, Z, a[9], a[8], a[9], a[8], Z, Z)
            + w8(Z, Z, a[11], a[10], a[11], a[10], a[11], a[10]);
      end
      FLD_224: begin
        pos = w8(Z, a[6], a[5], a[4], a[3], a[2], a[1], a[0])
            + w8(Z, a[10], a[9], a[8], a[7], Z, Z, Z)
            + w8(Z, Z, a[13], a[12], a[11], Z, Z, Z);
        neg = w8(Z, a[13], a[12], a[11], a[10], a[9], a[8], a[7])
            + w8(Z, Z, Z, Z, Z, a[13], a[12], a[11]);
      end
      FLD_256: begin
        pos = w8(a[7], a[6], a[5], a[4], a[3], a[2], a[1], a[0])
            + (w8(a[15], a[14], a[13], a[12], a[11], Z, Z, Z) << 1)
            + (w8(Z, a[15], a[14], a[13], a[12], Z, Z, Z) << 1)
            + w8(a[15], a[14], Z, Z, Z, a[10], a[9], a[8])
            + w8(a[8], a[13], a[15], a[14], a[13], a[11], a[10], a[9]);
        neg = w8(a[10], a[8], Z, Z, Z, a[13], a[12], a[11])
            + w8(a[11], a[9], Z, Z, a[15], a[14], a[13], a[12])
            + w8(a[12], Z, a[10], a[9], a[8], a[15], a[14], a[13])
            + w8(a[13], Z, a[11], a[10], a[9], Z, a[15], a[14]);
      end
      default: ;
    endcase
    offs = EXT_W'(prime_of(fld_i)) * EXT_W'(OFFSET_K);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      fld_o <= FLD_192;
    end else if (en) begin
      vld_o <= vld_i;
      fld_o <= fld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) ext_o <= pos + offs - neg;
  end
endmodule

// File: rtl/nfr_correct.sv
module nfr_correct
  import nfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vld_i,
  input  field_e           fld_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic             vld_o,
  output field_e           fld_o,
  output logic [RES_W-1:0] res_o
);
  logic [EXT_W-1:0] p_ext;
  logic [KMAX-1:0]  ge;
  logic [EXT_W-1:0] sub;

  assign p_ext = EXT_W'(prime_of(fld_i));

  for (genvar k = 1; k <= KMAX; k++) begin : g_cmp
    assign ge[k-1] = (ext_i >= p_ext * EXT_W'(k));
  end

  // thresholds are monotone, so the count of passed ones is the quotient
  always_comb begin
    sub = p_ext * EXT_W'($countones(ge));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      fld_o <= FLD_192;
    end else if (en) begin
      vld_o <= vld_i;
      fld_o <= fld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) res_o <= RES_W'(ext_i - sub);
  end
endmodule

// File: rtl/nfr_fast_reduce.sv
module nfr_fast_reduce
  import nfr_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [1:0]                          in_field,
  input  logic [nfr_pkg::PROD_W-1:0]          in_sum,
  input  logic [nfr_pkg::N_WORDS*nfr_pkg::CARRY_W-1:0] in_carry,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [1:0]                          out_field,
  output logic [nfr_pkg::RES_W-1:0]           out_data
);
  logic              adv;
  logic              v1, v2, v3;
  field_e            f1, f2, f3;
  logic [PROD_W-1:0] prod;
  logic [EXT_W-1:0]  ext;

  assign adv      = !v3 || out_ready;
  assign in_ready = adv;

  nfr_merge u_merge (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .vld_i(in_valid), .fld_i(field_e'(in_field)),
    .sum_i(in_sum), .carry_i(in_carry),
    .vld_o(v1), .fld_o(f1), .prod_o(prod)
  );

  nfr_fold u_fold (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .vld_i(v1), .fld_i(f1), .prod_i(prod),
    .vld_o(v2), .fld_o(f2), .ext_o(ext)
  );

  nfr_correct u_correct (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .vld_i(v2), .fld_i(f2), .ext_i(ext),
    .vld_o(v3), .fld_o(f3), .res_o(out_data)
  );

  assign out_valid = v3;
  assign out_field = f3;
endmodule

// File: rtl/nfr_checker.sv
module nfr_checker
  import nfr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_field,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_field,
  input logic [RES_W-1:0] out_data
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_field)); // R6

  AST_BELOW_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data < prime_of(field_e'(out_field))); // R3

  AST_TOP_BITS_CLEAR_192: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_field == 2'b00 |-> out_data[RES_W-1:192] == '0); // R3

  AST_TOP_BITS_CLEAR_224: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_field == 2'b01 |-> out_data[RES_W-1:224] == '0); // R3

  AST_NO_RESERVED_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_field != 2'b11); // R4

  AST_THREE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_field != 2'b11 ##1 out_ready ##1 out_ready |=> out_valid); // R5
endmodule

bind nfr_fast_reduce nfr_checker u_nfr_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_field(in_field), .out_valid(out_valid), .out_ready(out_ready),
  .out_field(out_field), .out_data(out_data)
);

// File: tb/test_nfr_fast_reduce.sv
module test_nfr_fast_reduce;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_field = 2'b00;
  logic [511:0] in_sum = '0;
  logic [127:0] in_carry = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [1:0]   out_field;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;
  bit fired;
  bit stalled_prev = 1'b0;
  logic [255:0] held_data;
  logic [255:0] exp_q[$];
  logic [1:0]   fld_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nfr_fast_reduce i_nfr_fast_reduce (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_field(in_field), .in_sum(in_sum), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_field(out_field), .out_data(out_data)
  );

  function automatic logic [511:0] modulus(input logic [1:0] f);
    logic [511:0] one = 512'd1;
    case (f)
      2'b00:   return (one << 192) - (one << 64) - 1;
      2'b01:   return (one << 224) - (one << 96) + 1;
      default: return (one << 256) - (one << 224) + (one << 192) + (one << 96) - 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, observe 1 time unit later
  task automatic step(input logic iv, input logic [1:0] f, input logic [511:0] z, input logic ordy);
    logic [127:0] cv;
    logic [511:0] csh;
    @(negedge clk);
    csh = '0;
    for (int j = 1; j <= 16; j++) begin
      cv[(j-1)*8 +: 8] = 8'($urandom);
      csh = csh + (512'(cv[(j-1)*8 +: 8]) << (32 * j));
    end
    in_valid  = iv;
    in_field  = f;
    in_carry  = cv;
    in_sum    = z - csh;
    out_ready = ordy;
    #1;
    fired = out_valid && out_ready;
    if (stalled_prev) begin
      check(out_valid && out_data == held_data, "R6 held beat", out_data, held_data);
    end
    if (out_valid && !out_ready) begin
      check(!in_ready, "R6 ready low", 256'(in_ready), 256'd0);
    end
    stalled_prev = out_valid && !out_ready;
    held_data = out_data;
    if (fired) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 stray beat", out_data, '0);
      end else begin
        logic [255:0] e = exp_q.pop_front();
        logic [1:0]   ef = fld_q.pop_front();
        check(out_data == e, "R1 residue", out_data, e);
        check(out_field == ef, "R6 field tag", 256'(out_field), 256'(ef));
      end
    end
    if (iv && in_ready && f != 2'b11) begin
      exp_q.push_back(256'(z % modulus(f)));
      fld_q.push_back(f);
    end
  endtask

  function automatic logic [511:0] rnd_below(input logic [511:0] lim);
    logic [511:0] r = '0;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
    return r % lim;
  endfunction

  task automatic drain();
    for (int k = 0; k < 6; k++) step(1'b0, 2'b00, '0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] p;
    int seen;
    #(CLK_PERIOD * 3 + 2);
    check(out_valid == 1'b0, "R7 valid in reset", 256'(out_valid), 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7 after reset",
          256'({out_valid, in_ready}), 256'b01);

    // edge products per field (R1, R3)
    for (int f = 0; f < 3; f++) begin
      p = modulus(2'(f));
      step(1'b1, 2'(f), '0, 1'b1);
      step(1'b1, 2'(f), p - 1, 1'b1);
      step(1'b1, 2'(f), p, 1'b1);
      step(1'b1, 2'(f), (p - 1) * (p - 1), 1'b1);
      step(1'b1, 2'(f), (512'd1 << (f == 0 ? 384 : f == 1 ? 448 : 511)) - 1 +
                        (f == 2 ? (512'd1 << 511) : 512'd0), 1'b1);
    end
    // U - V below zero (R8)
    step(1'b1, 2'b01, ((512'd1 << 96) - 1) << (32 * 11), 1'b1);
    step(1'b1, 2'b10, ((512'd1 << 128) - 1) << (32 * 12), 1'b1);
    step(1'b1, 2'b10, 512'hFFFF_FFFF << (32 * 13), 1'b1);
    step(1'b1, 2'b10, ((512'd1 << 96) - 1) << (32 * 8), 1'b1);
    drain();
    check(exp_q.size() == 0, "R8 queue empty", 256'(exp_q.size()), '0);

    // latency with out_ready high (R5)
    step(1'b1, 2'b10, 512'd12345, 1'b1);
    seen = 0;
    for (int k = 1; k <= 5; k++) begin
      step(1'b0, 2'b00, '0, 1'b1);
      if (fired && seen == 0) seen = k;
    end
    check(seen == 3, "R5 latency", 256'(seen), 256'd3);

    // back-to-back acceptance (R5)
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      p = modulus(2'(k % 3));
      step(1'b1, 2'(k % 3), rnd_below(p) * rnd_below(p), 1'b1);
      if (in_ready) seen++;
    end
    check(seen == 10, "R5 one per cycle", 256'(seen), 256'd10);
    drain();

    // reserved code yields no beat (R4)
    step(1'b1, 2'b11, 512'd999, 1'b1);
    step(1'b1, 2'b11, '1, 1'b1);
    drain();
    check(exp_q.size() == 0, "R4 no beat", 256'(exp_q.size()), '0);

    // random traffic, random carries, random stalls (R1, R2, R6)
    for (int k = 0; k < 1500; k++) begin
      logic [1:0] f = 2'($urandom_range(0, 3));
      p = modulus(f);
      step($urandom_range(0, 3) != 0, f, rnd_below(p) * rnd_below(p),
           $urandom_range(0, 9) < 7);
    end
    drain();
    check(exp_q.size() == 0, "R2 all results returned", 256'(exp_q.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule